// File: doc/BRIEF.md
# Serial ADC Output Register

This block is the digital back end of a 12-bit sampling converter that talks to its host over a three-wire serial link. The host raises a conversion-start line. A fixed number of system clocks later the new result is captured from a parallel test input into a result register. The host pulses a serial clock to read the result back, sixteen pulses per frame. The block gives no completion flag. The host knows a result is ready only because the conversion time is fixed.

Each frame holds four leading zeros followed by the 12-bit two's-complement result, MSB first. The output bit advances on every rising serial-clock edge, so the host samples it while the clock is high or on its falling edge. After the sixteenth pulse the frame logic returns to idle and the data pin is released. Pulses beyond the sixteenth are not blocked: they simply begin another frame. Every falling edge of the conversion-start line forces the frame logic back to idle, even in the middle of a read. Both host inputs are asynchronous and pass through a synchronizer into the system clock domain.

The serial link is clocked by the host, so there is no valid/ready pairing anywhere on it. The host itself paces each bit with the serial clock, which is the only form of back-pressure. The captured result needs no handshake because it is simply held until the next capture.

Top module: `adc_serial_out`

## Requirements
- R1: After reset the data-enable output is low and the result register holds zero, so a frame read before any conversion shifts out 16'h0000.
- R2: A frame is 16 rising serial-clock edges. Bits 15..12 are zero and bits 11..0 carry the captured result, MSB first. The enable output is high throughout the frame, and each bit stays valid from its rising edge until the next rising edge.
- R3: On the falling serial-clock edge that ends the sixteenth pulse, the enable output goes low and the bit position returns to zero.
- R4: A pulse after the sixteenth is not refused. It starts a new frame carrying the same result with the enable output high.
- R5: A falling edge of the conversion-start input forces the enable output low and the bit position to zero. The next read then starts again at bit 15.
- R6: A rising edge of the conversion-start input starts a conversion. The parallel input is captured exactly CONV_CYCLES system clocks after the synchronized edge. A change to the parallel input outside that cycle has no effect on the result.
- R7: A frame read while a conversion is running returns the previous result.
- R8: A result captured while a frame is in progress appears only in the next frame. The frame in progress keeps the old value.
- R9: The data output changes only in the cycle after a synchronized rising serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| convst_i | input | 1 | Conversion start from host, asynchronous |
| sclk_i | input | 1 | Serial clock from host, asynchronous |
| conv_data_i | input | 12 | Parallel result captured at conversion end |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | Drive enable for the serial data pin (low = high-impedance) |

## Verification
The frame is read back using results that tell different bit positions apart: zero, the largest positive code 12'h7FF, the most negative code 12'h800, a mixed pattern and a few smaller values. A result whose sign bit or ordering is wrong therefore shows up in the compare. Reads are placed in four positions relative to the conversion: before any conversion, entirely inside one, straddling the capture cycle, and after it. These tell apart the old result, the new result and a capture at the wrong time. Back-to-back frames with no conversion-start edge between them check that extra pulses wrap around. A read cut off by a conversion-start falling edge, followed by a full read, shows whether the forced reset really restarts the frame at bit 15.

// File: rtl/adc_so_pkg.sv
package adc_so_pkg;
  localparam int RES_BITS   = 12;
  localparam int FRAME_BITS = 16;
  localparam int PAD_BITS   = FRAME_BITS - RES_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS + 1);

  typedef logic [RES_BITS-1:0]   res_t;
  typedef logic [FRAME_BITS-1:0] frame_t;
  typedef logic [POS_W-1:0]      pos_t;

  function automatic frame_t make_frame(input res_t r);
    return {{PAD_BITS{1'b0}}, r};
  endfunction
endpackage

// File: rtl/adc_so_sync.sv
module adc_so_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign rise_o = chain[STAGES-1] & ~prev;
  assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/adc_so_conv.sv
module adc_so_conv
  import adc_so_pkg::*;
#(
  parameter int CONV_CYCLES = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  res_t data_i,
  output logic busy_o,
  output logic load_o,
  output res_t result_o
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] remain;

  assign load_o = busy_o && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      remain   <= '0;
      result_o <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      remain <= CNT_INIT;
    end else if (busy_o) begin
      if (remain == '0) begin
        busy_o   <= 1'b0;
        result_o <= data_i;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_so_shift.sv
module adc_so_shift
  import adc_so_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_rise_i,
  input  logic   sclk_fall_i,
  input  logic   force_idle_i,
  input  frame_t frame_i,
  output logic   sdata_o,
  output logic   oe_o,
  output pos_t   pos_o
);
  localparam pos_t LAST_POS = POS_W'(FRAME_BITS);

  frame_t shreg;

  assign sdata_o = shreg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      oe_o  <= 1'b0;
      pos_o <= '0;
    end else if (force_idle_i) begin
      oe_o  <= 1'b0;
      pos_o <= '0;
    end else if (sclk_rise_i) begin
      oe_o  <= 1'b1;
      pos_o <= (pos_o == LAST_POS) ? pos_t'(1) : pos_o + 1'b1;
      if (pos_o == '0 || pos_o == LAST_POS) shreg <= frame_i;
      else                                  shreg <= shreg << 1;
    end else if (sclk_fall_i && pos_o == LAST_POS) begin
      oe_o  <= 1'b0;
      pos_o <= '0;
    end
  end
endmodule

// File: rtl/adc_serial_out.sv
module adc_serial_out
  import adc_so_pkg::*;
#(
  parameter int CONV_CYCLES = 1500,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                convst_i,
  input  logic                sclk_i,
  input  logic [RES_BITS-1:0] conv_data_i,
  output logic                sdata_o,
  output logic                sdata_oe_o
);
  logic cv_rise, cv_fall;
  logic sclk_rise, sclk_fall;
  logic busy, load;
  res_t res_q;
  pos_t pos;

  adc_so_sync #(.STAGES(SYNC_STAGES)) i_sync_cv (
    .clk(clk), .rst_n(rst_n), .async_i(convst_i),
    .rise_o(cv_rise), .fall_o(cv_fall)
  );

  adc_so_sync #(.STAGES(SYNC_STAGES)) i_sync_sclk (
    .clk(clk), .rst_n(rst_n), .async_i(sclk_i),
    .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  adc_so_conv #(.CONV_CYCLES(CONV_CYCLES)) i_conv (
    .clk(clk), .rst_n(rst_n), .start_i(cv_rise), .data_i(conv_data_i),
    .busy_o(busy), .load_o(load), .result_o(res_q)
  );

  adc_so_shift i_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .force_idle_i(cv_fall), .frame_i(make_frame(res_q)),
    .sdata_o(sdata_o), .oe_o(sdata_oe_o), .pos_o(pos)
  );
endmodule

// File: rtl/adc_so_chk.sv
module adc_so_chk
  import adc_so_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cv_rise,
  input logic cv_fall,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic busy,
  input logic load,
  input res_t res_q,
  input pos_t pos,
  input logic sdata_o,
  input logic sdata_oe_o
);
  localparam pos_t LAST_POS = POS_W'(FRAME_BITS);

  AST_ENABLE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe_o) |-> $past(sclk_rise)); // R2
  AST_FIRST_BIT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe_o) |-> !sdata_o); // R2
  AST_FRAME_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && pos == LAST_POS && !cv_fall) |=> (!sdata_oe_o && pos == '0)); // R3
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST_POS); // R4
  AST_FORCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cv_fall |=> (!sdata_oe_o && pos == '0)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(res_q)); // R6
  AST_LOAD_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cv_rise) |=> !busy); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cv_rise |=> busy); // R6
  AST_DATA_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(sdata_o)); // R9
endmodule

bind adc_serial_out adc_so_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cv_rise(cv_rise), .cv_fall(cv_fall),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .busy(busy), .load(load),
  .res_q(res_q), .pos(pos), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o)
);

// File: tb/test_adc_serial_out.sv
module test_adc_serial_out;
  localparam int HALF = 6;
  localparam int CONV = 1500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        convst = 1'b0;
  logic        sclk = 1'b0;
  logic [11:0] cdata = '0;
  logic        sdata, oe;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] exp_q[$];
  logic [15:0] got_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  adc_serial_out #(.CONV_CYCLES(CONV)) i_adc_serial_out (
    .clk(clk), .rst_n(rst_n), .convst_i(convst), .sclk_i(sclk),
    .conv_data_i(cdata), .sdata_o(sdata), .sdata_oe_o(oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(output logic b, output logic en);
    @(negedge clk) sclk = 1'b1;
    wait_cyc(HALF);
    b  = sdata;
    en = oe;
    sclk = 1'b0;
    wait_cyc(HALF);
  endtask

  // Driver: pushes the expected frame, then clocks a frame out.
  task automatic read_frame(input logic [11:0] res, input string tag);
    logic [15:0] w;
    logic b, en, all_en;
    all_en = 1'b1;
    w = '0;
    exp_q.push_back({4'h0, res});
    tag_q.push_back(tag);
    for (int i = 0; i < 16; i++) begin
      pulse(b, en);
      w = {w[14:0], b};
      all_en &= en;
    end
    check(all_en, {tag, " R2 enable high during frame"}, all_en, 1);
    check(!oe, {tag, " R3 enable low after 16th pulse"}, oe, 0);
    got_q.push_back(w);
  endtask

  task automatic convert(input logic [11:0] d);
    @(negedge clk) begin cdata = d; convst = 1'b1; end
  endtask

  // Monitor: compares collected frames against the expected queue.
  initial begin
    forever begin
      wait (got_q.size() > 0 && exp_q.size() > 0);
      begin
        logic [15:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g == e, t, g, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic b, en;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    check(!oe, "R1 enable low after reset", oe, 0);

    read_frame(12'h000, "R1 frame before any conversion");

    convert(12'h7FF);
    wait_cyc(CONV + 100);
    convst = 1'b0;
    wait_cyc(10);
    read_frame(12'h7FF, "R2 R6 largest positive");

    convert(12'h800);
    wait_cyc(CONV + 100);
    convst = 1'b0;
    wait_cyc(10);
    read_frame(12'h800, "R2 most negative");

    convert(12'hA5C);
    wait_cyc(CONV + 100);
    cdata = 12'hFFF;
    convst = 1'b0;
    wait_cyc(10);
    read_frame(12'hA5C, "R6 input change after capture ignored");

    convert(12'h123);
    wait_cyc(20);
    read_frame(12'hA5C, "R7 read during conversion keeps old");
    wait_cyc(CONV + 100);
    convst = 1'b0;
    wait_cyc(10);
    read_frame(12'h123, "R6 R7 read after conversion");

    read_frame(12'h123, "R4 extra pulses wrap to new frame");
    pulse(b, en);
    check(en == 1'b1, "R4 enable high on 33rd pulse", en, 1);
    check(b == 1'b0, "R4 pad bit on 33rd pulse", b, 0);
    for (int i = 0; i < 4; i++) pulse(b, en);

    convert(12'h3C3);
    wait_cyc(20);
    convst = 1'b0;
    wait_cyc(10);
    check(!oe, "R5 enable forced low mid frame", oe, 0);
    wait_cyc(CONV + 100);
    read_frame(12'h3C3, "R5 frame restarts at bit 15");

    convert(12'h456);
    wait_cyc(CONV - 80);
    read_frame(12'h3C3, "R8 frame straddling capture keeps old");
    wait_cyc(50);
    convst = 1'b0;
    wait_cyc(10);
    read_frame(12'h456, "R8 next frame has new result");

    wait (got_q.size() == 0);
    wait_cyc(5);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule